// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block stands between a host's active-low static-memory strobes (chip enable, write enable, output enable) and a memory array. A digital power-fail flag, already produced by an external comparator, is synchronised inside the block. When the flag rises, the block stops any new access from reaching the array and turns off the data-output drive. An access that is already under way is allowed to finish, but only up to a bounded timeout. When the flag clears, the block keeps the array protected for a recovery interval. The length of that interval depends on a supply-mode input.

All strobe outputs, the output-drive enable and the protect status are registered. They follow the host strobes with one clock of latency. A separate flag reports that battery backup has been armed. It is set the first time the block sees good power and is never cleared again except by reset. The timeout and the two recovery intervals are given in microseconds and turned into clock counts from a clock-frequency parameter.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is high, `wp` is 1, all three array strobes are 1, `dq_oe` is 0 and `bk_armed` is 0.
- R2: While `wp` is 1, all array strobes are 1 and `dq_oe` is 0, whatever the values of `ce_n`, `we_n` and `oe_n`.
- R3: When unprotected, the outputs follow the host strobes one clock later, decoded as follows. `ce_n`=1 deselects the array: all strobes are 1 and `dq_oe`=0. `ce_n`=0 with `we_n`=0 is a write: `arr_ce_n`=0, `arr_we_n`=0, `arr_oe_n`=1, `dq_oe`=0, whatever `oe_n` is. `ce_n`=0, `we_n`=1, `oe_n`=0 is a read: `arr_ce_n`=0, `arr_oe_n`=0, `dq_oe`=1. `ce_n`=0, `we_n`=1, `oe_n`=1 disables the output: only `arr_ce_n`=0.
- R4: If `ce_n` is 0 at the edge where the synchronised power-fail is first seen, the access continues. `wp` rises at the first edge at which `ce_n` is 1.
- R5: If that access is still running after TW = CLK_HZ/1e6·TWPT_US cycles, `wp` rises anyway. This happens exactly 3+TW edges after `pf_async` rises, and it cuts off all strobes.
- R6: After `pf_async` falls, `wp` falls exactly 3+REC edges later. REC is the high-supply recovery count when `mode_lo`=0 and the low-supply count when `mode_lo`=1.
- R7: If `pf_async` rises again during recovery, protection stays on. The full recovery count restarts once `pf_async` falls again.
- R8: `bk_armed` becomes 1 after power is first seen good and stays 1 through later power failures.
- R9: If `ce_n` is 1 when the power-fail is detected, `wp` rises 3 edges after `pf_async` rises.
- R10: After reset, no access reaches the array until a full recovery interval has passed with power good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_async | input | 1 | Power-fail flag, 1 = supply failing |
| mode_lo | input | 1 | 1 selects the low-supply recovery interval |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| arr_ce_n | output | 1 | Gated chip enable to the array |
| arr_we_n | output | 1 | Gated write enable to the array |
| arr_oe_n | output | 1 | Gated output enable to the array |
| dq_oe | output | 1 | Data-output drive enable |
| wp | output | 1 | Write-protect status |
| bk_armed | output | 1 | Battery backup armed |

## Verification
The assertions assume the following about the inputs. The host strobes are synchronous to `clk` and are sampled raw by the state machine. A power-fail flag that rises while the block is unprotected stays high at least until protection takes hold, so the drain-window counter in the checker measures one clean episode. The bench meets both assumptions: it changes every input only just after a falling edge, and it holds `pf_async` steady through each drain and recovery window that it times, except in the deliberate re-assertion during recovery.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
  typedef enum logic [1:0] {
    ST_RECOVER = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_DRAIN   = 2'd2,
    ST_PROT    = 2'd3
  } pf_state_e;

  function automatic int us_to_cyc(input int clk_hz, input int us);
    return (clk_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pfwp_decode.sv
module pfwp_decode (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic arr_ce_n,
  output logic arr_we_n,
  output logic arr_oe_n,
  output logic dq_oe
);
  logic sel, wr, rd;

  always_comb begin
    sel = allow && !ce_n;
    wr  = sel && !we_n;
    rd  = sel && we_n && !oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_ce_n <= 1'b1;
      arr_we_n <= 1'b1;
      arr_oe_n <= 1'b1;
      dq_oe    <= 1'b0;
    end else begin
      arr_ce_n <= !sel;
      arr_we_n <= !wr;
      arr_oe_n <= !rd;
      dq_oe    <= rd;
    end
  end
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int TWPT_US   = 10,
  parameter int REC_HI_US = 120_000,
  parameter int REC_LO_US = 85_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pf_async,
  input  logic mode_lo,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic arr_ce_n,
  output logic arr_we_n,
  output logic arr_oe_n,
  output logic dq_oe,
  output logic wp,
  output logic bk_armed
);
  import pfwp_pkg::*;

  localparam int TW_CYC  = us_to_cyc(CLK_HZ, TWPT_US);
  localparam int RH_CYC  = us_to_cyc(CLK_HZ, REC_HI_US);
  localparam int RL_CYC  = us_to_cyc(CLK_HZ, REC_LO_US);
  localparam int MAX_CYC = (RH_CYC > RL_CYC) ?
                           ((RH_CYC > TW_CYC) ? RH_CYC : TW_CYC) :
                           ((RL_CYC > TW_CYC) ? RL_CYC : TW_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] TW_LIM = CW'(TW_CYC - 1);
  localparam logic [CW-1:0] RH_LIM = CW'(RH_CYC - 1);
  localparam logic [CW-1:0] RL_LIM = CW'(RL_CYC - 1);

  logic          pf_s;
  logic          clr, inc;
  logic [CW-1:0] cnt;
  logic [CW-1:0] rec_lim;
  pf_state_e     st, nxt;

  pfwp_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pf_async), .q(pf_s)
  );

  pfwp_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc), .cnt(cnt)
  );

  assign rec_lim = mode_lo ? RL_LIM : RH_LIM;

  always_comb begin
    nxt = st;
    clr = 1'b0;
    inc = 1'b0;
    unique case (st)
      ST_RECOVER: begin
        if (pf_s) begin
          nxt = ST_PROT;
          clr = 1'b1;
        end else if (cnt == rec_lim) begin
          nxt = ST_ACTIVE;
          clr = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (pf_s) begin
          clr = 1'b1;
          nxt = ce_n ? ST_PROT : ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (ce_n || cnt == TW_LIM) begin
          nxt = ST_PROT;
          clr = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      ST_PROT: begin
        if (!pf_s) begin
          nxt = ST_RECOVER;
          clr = 1'b1;
        end
      end
      default: nxt = ST_PROT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RECOVER;
      wp       <= 1'b1;
      bk_armed <= 1'b0;
    end else begin
      st       <= nxt;
      wp       <= (nxt == ST_RECOVER) || (nxt == ST_PROT);
      bk_armed <= bk_armed | !pf_s;
    end
  end

  pfwp_decode u_dec (
    .clk(clk), .rst(rst),
    .allow((nxt == ST_ACTIVE) || (nxt == ST_DRAIN)),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n),
    .arr_oe_n(arr_oe_n), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/pfwp_chk.sv
module pfwp_chk #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TWPT_US = 10
) (
  input logic clk,
  input logic rst,
  input logic pf_async,
  input logic arr_ce_n,
  input logic arr_we_n,
  input logic arr_oe_n,
  input logic dq_oe,
  input logic wp,
  input logic bk_armed
);
  localparam int TW_CYC = (CLK_HZ / 1_000_000) * TWPT_US;
  localparam int HW     = $clog2(TW_CYC + 8);

  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst)                  hold <= '0;
    else if (pf_async && !wp) hold <= (hold == {HW{1'b1}}) ? hold : hold + 1'b1;
    else                      hold <= '0;
  end

  a_r1_reset_safe: assert property (@(posedge clk)
    rst |=> (wp && !bk_armed && arr_ce_n && arr_we_n && arr_oe_n && !dq_oe));

  a_r2_protect_blocks: assert property (@(posedge clk) disable iff (rst)
    wp |-> (arr_ce_n && arr_we_n && arr_oe_n && !dq_oe));

  a_r3_read_shape: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!arr_ce_n && !arr_oe_n && arr_we_n));

  a_r3_write_shape: assert property (@(posedge clk) disable iff (rst)
    !arr_we_n |-> (!arr_ce_n && arr_oe_n && !dq_oe));

  a_r5_drain_bounded: assert property (@(posedge clk) disable iff (rst)
    hold <= HW'(TW_CYC + 3));

  a_r8_armed_sticks: assert property (@(posedge clk) disable iff (rst)
    bk_armed |=> bk_armed);
endmodule

bind pfwp_ctrl pfwp_chk #(.CLK_HZ(CLK_HZ), .TWPT_US(TWPT_US)) u_chk (
  .clk(clk), .rst(rst), .pf_async(pf_async),
  .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .arr_oe_n(arr_oe_n),
  .dq_oe(dq_oe), .wp(wp), .bk_armed(bk_armed)
);

// File: tb/sim_pfwp_ctrl.sv
module sim_pfwp_ctrl;
  localparam int CLK_HZ = 1_000_000;
  localparam int TWP    = 12;
  localparam int RHI    = 30;
  localparam int RLO    = 18;
  localparam int TW = TWP, RH = RHI, RL = RLO;

  logic clk = 1'b0;
  logic rst, pf_async, mode_lo, ce_n, we_n, oe_n;
  logic arr_ce_n, arr_we_n, arr_oe_n, dq_oe, wp, bk_armed;
  int   n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pfwp_ctrl #(.CLK_HZ(CLK_HZ), .TWPT_US(TWP), .REC_HI_US(RHI), .REC_LO_US(RLO)) u0 (
    .clk(clk), .rst(rst), .pf_async(pf_async), .mode_lo(mode_lo),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .arr_oe_n(arr_oe_n),
    .dq_oe(dq_oe), .wp(wp), .bk_armed(bk_armed)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {arr_ce_n, arr_we_n, arr_oe_n, dq_oe};
  endfunction

  task automatic wait_wp(input logic val, output int n, output bit leak);
    n = 0;
    leak = 0;
    while (wp !== val && n < 2000) begin
      tick();
      n++;
      if (wp === 1'b1 && outs() !== 4'b1110) leak = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int  n;
    bit  leak;
    logic [3:0] exp;

    rst = 1; pf_async = 1; mode_lo = 0; ce_n = 1; we_n = 1; oe_n = 1;
    @(negedge clk);
    repeat (3) tick();
    check(wp === 1 && outs() === 4'b1110 && bk_armed === 0, "R1", {wp, bk_armed, 4'(outs())}, 6'b101110);

    // R10/R2: host attempts a read while power still failing after reset
    rst = 0; ce_n = 0; we_n = 1; oe_n = 0;
    repeat (6) tick();
    check(wp === 1 && outs() === 4'b1110, "R2", outs(), 4'b1110);
    check(bk_armed === 0, "R8", bk_armed, 0);

    pf_async = 0;
    wait_wp(0, n, leak);
    check(n == 3 + RH, "R6 high-mode recovery after reset", n, 3 + RH);
    check(!leak, "R10", leak, 0);
    check(dq_oe === 1, "R10 read allowed after recovery", dq_oe, 1);
    check(bk_armed === 1, "R8", bk_armed, 1);

    // R3: sweep all strobe combinations while unprotected
    for (int i = 0; i < 8; i++) begin
      {ce_n, we_n, oe_n} = 3'(i);
      tick();
      if (ce_n) exp = 4'b1110;
      else if (!we_n) exp = 4'b0010;
      else if (!oe_n) exp = 4'b0101;
      else exp = 4'b0110;
      check(outs() === exp && wp === 0, "R3", outs(), exp);
    end

    // R9: power fails with no access in progress
    ce_n = 1; we_n = 1; oe_n = 1;
    tick();
    pf_async = 1;
    wait_wp(1, n, leak);
    check(n == 3, "R9", n, 3);

    // R2: strobes ignored while protected
    for (int i = 0; i < 8; i++) begin
      {ce_n, we_n, oe_n} = 3'(i);
      tick();
      check(outs() === 4'b1110 && wp === 1, "R2", outs(), 4'b1110);
    end
    check(bk_armed === 1, "R8 armed kept through power-down", bk_armed, 1);

    // R7: power-fail returns during recovery
    ce_n = 1; we_n = 1; oe_n = 1;
    pf_async = 0;
    repeat (3 + RH / 2) tick();
    check(wp === 1, "R7 still recovering", wp, 1);
    pf_async = 1;
    repeat (6) tick();
    check(wp === 1, "R7", wp, 1);
    pf_async = 0;
    wait_wp(0, n, leak);
    check(n == 3 + RH, "R7 full restart", n, 3 + RH);

    // R6: low-supply mode recovery
    mode_lo = 1;
    pf_async = 1;
    wait_wp(1, n, leak);
    pf_async = 0;
    wait_wp(0, n, leak);
    check(n == 3 + RL, "R6 low-mode recovery", n, 3 + RL);

    // R4: write in progress completes when CE returns high
    ce_n = 0; we_n = 0; oe_n = 1;
    tick();
    pf_async = 1;
    repeat (6) tick();
    check(wp === 0 && outs() === 4'b0010, "R4 access continues", outs(), 4'b0010);
    ce_n = 1;
    wait_wp(1, n, leak);
    check(n == 1, "R4", n, 1);
    check(outs() === 4'b1110, "R4 strobes off", outs(), 4'b1110);

    // R5: access that never ends is cut off by the timeout
    pf_async = 0;
    wait_wp(0, n, leak);
    ce_n = 0; we_n = 1; oe_n = 0;
    tick();
    check(dq_oe === 1, "R3 read before fail", dq_oe, 1);
    pf_async = 1;
    wait_wp(1, n, leak);
    check(n == 3 + TW, "R5", n, 3 + TW);
    check(outs() === 4'b1110, "R5 cut off", outs(), 4'b1110);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule